// File: doc/BRIEF.md
# Cascadable Successive-Approximation Register

This block holds the trial word and the control sequence for a successive-approximation analog-to-digital converter. A start request loads the most significant trial bit. On each following rising clock edge the comparator result decides the current trial bit, and the next lower bit is raised as the new trial. After the last bit has been decided, a done flag rises on the next falling clock edge. The result word stays on the parallel outputs until the next restart or clear. The serial output presents each bit in the clock period right after that bit is decided.

A start is decoded from the present and previous values of the start request and the synchronous clear, sampled together. When the clear is released while the start request is low, the register stays in its all-zero state. That stable idle state lets the block act as the lower stage of a cascaded converter: an upper stage's done flag drives this stage's start request. The bench plays the part of an ideal digital-to-analog converter and comparator.

Top module: `sarRegister`

## Requirements
- R1: With masterClr high at a rising edge, resultQ is all zero and serialOut is low after that edge, and convDone is low from the following falling edge. This holds whatever startReq is.
- R2: A start is taken at a rising edge when startReq=1 and masterClr=0, and at the previous edge either startReq was 0 or masterClr was 1. After a start edge resultQ is 1000_0000 (only bit W-1 set), serialOut is low, and convDone is low from the following falling edge.
- R3: While startReq stays high with masterClr low, no new start occurs. A conversion in progress runs on, and a finished result is kept with convDone high.
- R4: After masterClr is released with startReq low, resultQ stays all zero and convDone stays low until startReq rises. The edge where startReq is first seen high starts a conversion.
- R5: In the k-th rising edge after a start (k = 1..W), cmpIn decides bit W-k: 1 keeps it, 0 clears it. At the same edge bit W-k-1 (if any) is set high as the next trial.
- R6: A decided bit keeps its value until a clear or a restart. Lowering startReq during a conversion does not stop it.
- R7: convDone goes high at the falling edge that follows the W-th decision edge. It is still low just after that rising edge, and it stays high until a clear or a start.
- R8: serialOut equals the value given to a bit during the clock period that follows that bit's decision edge. It is low in the period after a start, while cleared, and after the last bit's period.
- R9: With cmpIn = (input code >= resultQ) from an ideal converter, the final resultQ equals the input code for any 8-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| startReq | input | 1 | Start-convert request |
| masterClr | input | 1 | Synchronous clear to the stable reset state |
| cmpIn | input | 1 | Comparator decision for the current trial bit |
| resultQ | output | W | Trial / result word to the converter and parallel data |
| convDone | output | 1 | End of conversion, updated on the falling edge |
| serialOut | output | 1 | Serial result, MSB first |

## Verification
The hardest case to reach is the start decode when masterClr and startReq change on the same or adjacent edges. This covers a clear released while the request is already high, a clear released while the request is low, and a request dropped and raised again during a running conversion. Directed sequences drive each of these orderings and check the word right after the deciding edge. Randomized conversions then check, step by step, the held and dropped start request, with the input code and request level drawn from a seeded generator.

// File: rtl/sarRegPkg.sv
package sarRegPkg;
  typedef struct packed {
    logic clearAll;
    logic loadTop;
    logic decide;
  } sarStrobeT;
endpackage

// File: rtl/sarControl.sv
module sarControl
  import sarRegPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      masterClr,
  input  logic      lastTrial,
  output sarStrobeT strobe,
  output logic      convDone
);
  logic scPrev, mrPrev, busy, resultValid, doneFall;
  logic startHit, finishHit;

  // a start needs a fresh request or a request seen right after a clear
  assign startHit  = startReq & ~masterClr & (~scPrev | mrPrev);
  assign finishHit = strobe.decide & lastTrial;

  always_comb begin
    strobe.clearAll = masterClr;
    strobe.loadTop  = startHit;
    strobe.decide   = busy & ~masterClr & ~startHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scPrev      <= 1'b0;
      mrPrev      <= 1'b0;
      busy        <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      scPrev <= startReq;
      mrPrev <= masterClr;
      if (masterClr) begin
        busy        <= 1'b0;
        resultValid <= 1'b0;
      end else if (startHit) begin
        busy        <= 1'b1;
        resultValid <= 1'b0;
      end else if (finishHit) begin
        busy        <= 1'b0;
        resultValid <= 1'b1;
      end
    end
  end

  // done flag moves half a cycle after the rising-edge state settles
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) doneFall <= 1'b0;
    else       doneFall <= resultValid;
  end

  assign convDone = doneFall;

  assert_clear_idles_R1: assert property (@(posedge clk) disable iff (!rstN)
    masterClr |=> (!busy && !resultValid));

  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rstN)
    startHit |=> (busy && !resultValid));

  assert_no_restart_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (scPrev && !mrPrev) |-> !strobe.loadTop);

  assert_done_tracks_R7: assert property (@(posedge clk) disable iff (!rstN)
    convDone == resultValid);

  assert_done_sticks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !masterClr && !startHit) |=> resultValid);
endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarRegPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  sarStrobeT    strobe,
  input  logic         cmpIn,
  output logic [W-1:0] resultQ,
  output logic         serialOut,
  output logic         lastTrial
);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] qReg, qNext, trialPtr, ptrNext, raiseNext;
  logic         serialReg;

  assign raiseNext = trialPtr >> 1;

  for (genvar i = 0; i < W; i++) begin : gBit
    assign qNext[i] = strobe.clearAll                  ? 1'b0 :
                      strobe.loadTop                   ? TOP[i] :
                      (strobe.decide && trialPtr[i])   ? cmpIn :
                      (strobe.decide && raiseNext[i])  ? 1'b1 :
                                                         qReg[i];
  end

  always_comb begin
    if (strobe.clearAll)     ptrNext = '0;
    else if (strobe.loadTop) ptrNext = TOP;
    else if (strobe.decide)  ptrNext = raiseNext;
    else                     ptrNext = trialPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qReg      <= '0;
      trialPtr  <= '0;
      serialReg <= 1'b0;
    end else begin
      qReg     <= qNext;
      trialPtr <= ptrNext;
      if (strobe.clearAll || strobe.loadTop) serialReg <= 1'b0;
      else if (strobe.decide)                serialReg <= cmpIn;
      else                                   serialReg <= 1'b0;
    end
  end

  assign resultQ   = qReg;
  assign serialOut = serialReg;
  assign lastTrial = trialPtr[0];

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (resultQ == '0 && !serialOut));

  assert_load_top_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTop |=> (resultQ == TOP && !serialOut));

  assert_ptr_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trialPtr));

  assert_upper_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide |=> (((resultQ ^ $past(resultQ)) &
                        ~($past(trialPtr) | ($past(trialPtr) >> 1))) == '0));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.decide && !strobe.clearAll && !strobe.loadTop) |=>
      ($stable(resultQ) && !serialOut));

  assert_serial_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide |=> (serialOut == $past(cmpIn)));
endmodule

// File: rtl/sarRegister.sv
module sarRegister #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         masterClr,
  input  logic         cmpIn,
  output logic [W-1:0] resultQ,
  output logic         convDone,
  output logic         serialOut
);
  import sarRegPkg::*;

  sarStrobeT strobe;
  logic      lastTrial;

  sarControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .masterClr (masterClr),
    .lastTrial (lastTrial),
    .strobe    (strobe),
    .convDone  (convDone)
  );

  sarDatapath #(.W(W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmpIn     (cmpIn),
    .resultQ   (resultQ),
    .serialOut (serialOut),
    .lastTrial (lastTrial)
  );
endmodule

// File: tb/sarRegister_test.sv
module sarRegister_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic         masterClr = 1'b0;
  logic         cmpIn = 1'b0;
  logic [W-1:0] resultQ;
  logic         convDone;
  logic         serialOut;

  int checks = 0;
  int errors = 0;

  sarRegister #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .masterClr(masterClr),
    .cmpIn(cmpIn), .resultQ(resultQ), .convDone(convDone), .serialOut(serialOut)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W-1:0] stepModel(input logic [W-1:0] q, input int b, input bit d);
    logic [W-1:0] r;
    r = q;
    if (!d) r[b] = 1'b0;
    if (b > 0) r[b-1] = 1'b1;
    return r;
  endfunction

  // run n decision edges after a start, comparator fed from vin
  task automatic runSteps(input logic [W-1:0] vin, input int n);
    logic [W-1:0] expQ;
    expQ = {1'b1, {(W-1){1'b0}}};
    for (int k = 0; k < n; k++) begin
      int b;
      bit d;
      b = W - 1 - k;
      d = (vin >= resultQ);
      cmpIn = d;
      tick();
      expQ = stepModel(expQ, b, d);
      check(resultQ == expQ, "R5 trial step", resultQ, expQ);
      check(serialOut == d, "R8 serial bit", serialOut, d);
      check(convDone == 1'b0, "R7 done low during run", convDone, 0);
    end
    if (n == W) begin
      check(resultQ == vin, "R9 final code", resultQ, vin);
      @(negedge clk);
      #1;
      check(convDone == 1'b1, "R7 done after falling edge", convDone, 1);
      cmpIn = 1'b0;
      tick();
      check(serialOut == 1'b0, "R8 serial low after last bit", serialOut, 0);
      check(resultQ == vin, "R6 result held", resultQ, vin);
    end
  endtask

  task automatic doStart();
    startReq = 1'b0;
    tick();
    startReq = 1'b1;
    tick();
    check(resultQ == 8'h80, "R2 start loads top", resultQ, 8'h80);
    check(serialOut == 1'b0, "R2 serial low at start", serialOut, 0);
  endtask

  task automatic runConv(input logic [W-1:0] vin, input bit holdSc);
    doStart();
    if (!holdSc) startReq = 1'b0;
    runSteps(vin, W);
    for (int i = 0; i < 3; i++) begin
      cmpIn = $urandom() % 2;
      tick();
      check(resultQ == vin && convDone, "R3 result kept", resultQ, vin);
    end
  endtask

  initial begin
    void'($urandom(32'h5a17));
    repeat (2) tick();
    check(resultQ == 0 && !convDone && !serialOut, "R1 reset state", resultQ, 0);
    rstN = 1'b1;
    tick();

    runConv(8'h00, 1'b1);
    runConv(8'hFF, 1'b0);
    runConv(8'h80, 1'b1);
    runConv(8'h01, 1'b0);
    runConv(8'h7F, 1'b1);

    // R1: clear during a running conversion with the request high
    doStart();
    runSteps(8'hA5, 2);
    masterClr = 1'b1;
    tick();
    check(resultQ == 0 && !serialOut, "R1 clear mid run", resultQ, 0);
    // R4: release clear with request low, stays idle
    masterClr = 1'b0;
    startReq = 1'b0;
    for (int i = 0; i < 5; i++) begin
      cmpIn = $urandom() % 2;
      tick();
      check(resultQ == 0 && !convDone && !serialOut, "R4 stays reset", resultQ, 0);
    end
    startReq = 1'b1;
    tick();
    check(resultQ == 8'h80, "R4 start on request rise", resultQ, 8'h80);
    runSteps(8'h3C, W);

    // R1: clear after done with request low, done drops at falling edge
    startReq = 1'b0;
    masterClr = 1'b1;
    tick();
    check(resultQ == 0, "R1 clear after done", resultQ, 0);
    @(negedge clk);
    #1;
    check(convDone == 1'b0, "R1 done cleared", convDone, 0);

    // R2: clear released while request already high starts at once
    startReq = 1'b1;
    tick();
    masterClr = 1'b0;
    tick();
    check(resultQ == 8'h80, "R2 start after clear release", resultQ, 8'h80);
    runSteps(8'hC3, W);

    // R2/R6: request dropped then raised mid run restarts
    doStart();
    startReq = 1'b0;
    runSteps(8'h55, 3);
    startReq = 1'b1;
    tick();
    check(resultQ == 8'h80, "R2 restart mid run", resultQ, 8'h80);
    startReq = 1'b0;
    runSteps(8'h96, W);

    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] v;
      v = W'($urandom());
      runConv(v, bit'($urandom() % 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule